// File: doc/BRIEF.md
# Floating-Point Conditional Select Unit

This unit runs one instruction: a branch-free conditional select on 64-bit double-precision values. It holds a 32-entry register file. A valid strobe brings in a 32-bit instruction word. The unit checks the two opcode fields and reads three source registers, called key, else-value and then-value. One clock after it accepts the instruction, it writes the chosen value into the destination register.

The select test works on the raw bits of the key. The key passes when it is not a NaN and either its sign bit is clear or it is a zero of either sign. A passing key routes the then-value to the destination. Any other key, including every NaN and every negative nonzero value, routes the else-value. The value is copied bit for bit. No status flag is raised or altered. A record bit in the word makes the unit also load a 4-bit condition field from four status flags given at its input.

A side port lets a loader or a debugger fill the register file and read any entry. A result that is still waiting to be written is forwarded to an instruction that immediately follows and reads that register.

Top module: `fsel_unit`

## Requirements
- R1: After reset, every register reads 0, `cond_fld` is 4'b0000 and `illegal` is 0.
- R2: The word is accepted when bits [31:26] equal 63 and bits [5:1] equal 23. In that word, bits [25:21] name the destination, [20:16] the key, [15:11] the else-value, [10:6] the then-value and bit [0] is the record bit, so the base word is 32'hFC00002E.
- R3: A key that is +0, -0, a positive normal, a positive subnormal or +infinity writes the then-value.
- R4: A key that is a NaN of either sign, quiet or signalling, or that is a negative nonzero value including -infinity, writes the else-value. A NaN has all exponent bits [62:52] set and a nonzero fraction [51:0].
- R5: The destination receives an exact bit copy of the chosen source, including NaN payloads.
- R6: The destination is written at the second rising edge after the accepting edge's cycle begins, so it still holds its old value one clock after acceptance and holds the new value after the following edge.
- R7: With record bit 1, `cond_fld` takes `stat_flags` as sampled in the accepting cycle, at the same edge as the register write. The bits are ordered summary-exception in bit 3, enabled-exception in bit 2, invalid-operation in bit 1 and overflow in bit 0. With record bit 0, `cond_fld` does not change.
- R8: A valid word whose opcodes do not match drives `illegal` high for exactly the next cycle. It changes no register and does not change `cond_fld`.
- R9: A load write (`ld_we`) is visible on `dbg_data` after the next rising edge. Nothing changes while `insn_valid` is low.
- R10: An instruction that reads a register in the cycle right after an earlier instruction targeted it sees the earlier result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word strobe |
| insn_word | input | 32 | Instruction word |
| stat_flags | input | 4 | Status flags {summary, enabled, invalid, overflow} |
| ld_we | input | 1 | Load port write enable |
| ld_addr | input | 5 | Load port register index |
| ld_data | input | 64 | Load port write data |
| dbg_addr | input | 5 | Debug read index |
| dbg_data | output | 64 | Debug read data (register file contents) |
| cond_fld | output | 4 | Condition field |
| illegal | output | 1 | One-cycle pulse for a rejected word |

## Verification
The bench builds the unit with its default parameters: a 64-bit data width with an 11-bit exponent, and a 32-entry register file addressed by 5-bit fields. These settings put every IEEE double class within reach as a key, including both zeros, subnormals, both infinities and quiet and signalling NaNs. They also let source and destination indices cover the whole field width. The forwarding path and the write timing are reached by issuing instructions back to back and by probing a destination register between the two edges.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int INSN_W  = 32;
  localparam int FLD_W   = 5;
  localparam int PRIM_W  = 6;
  localparam int XO_W    = 5;
  localparam int FLAG_W  = 4;
  localparam logic [PRIM_W-1:0] PRIM_SEL = 6'd63;
  localparam logic [XO_W-1:0]   XO_SEL   = 5'd23;

  typedef struct packed {
    logic [PRIM_W-1:0] prim;
    logic [FLD_W-1:0]  dst;
    logic [FLD_W-1:0]  key;
    logic [FLD_W-1:0]  els;
    logic [FLD_W-1:0]  thn;
    logic [XO_W-1:0]   xo;
    logic              rec;
  } sel_word_t;

  function automatic sel_word_t split_word(input logic [INSN_W-1:0] w);
    sel_word_t s;
    s = sel_word_t'(w);
    return s;
  endfunction

  function automatic logic word_hits(input sel_word_t s);
    return (s.prim == PRIM_SEL) && (s.xo == XO_SEL);
  endfunction

  // exponent field saturated and fraction nonzero
  function automatic logic val_is_nan(input logic [63:0] v);
    return (&v[62:52]) && (|v[51:0]);
  endfunction

  function automatic logic val_is_zero(input logic [63:0] v);
    return ~|v[62:0];
  endfunction

  function automatic logic key_passes(input logic [63:0] v);
    return !val_is_nan(v) && (!v[63] || val_is_zero(v));
  endfunction
endpackage

// File: rtl/fsel_decode.sv
module fsel_decode
  import fsel_pkg::*;
(
  input  logic              valid,
  input  logic [INSN_W-1:0] word,
  output sel_word_t         fields,
  output logic              hit,
  output logic              miss
);
  logic match;

  always_comb begin
    fields = split_word(word);
    match  = word_hits(fields);
    hit    = valid && match;
    miss   = valid && !match;
  end
endmodule

// File: rtl/fsel_regfile.sv
module fsel_regfile #(
  parameter int NREG = 32,
  parameter int DW   = 64,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          wb_we,
  input  logic [AW-1:0] wb_addr,
  input  logic [DW-1:0] wb_data,
  input  logic [AW-1:0] rk_addr,
  input  logic [AW-1:0] re_addr,
  input  logic [AW-1:0] rt_addr,
  input  logic [AW-1:0] dbg_addr,
  output logic [DW-1:0] rk_data,
  output logic [DW-1:0] re_data,
  output logic [DW-1:0] rt_data,
  output logic [DW-1:0] dbg_data
);
  logic [DW-1:0] ent [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    logic [DW-1:0] q;
    logic          hit_wb, hit_ld;
    assign hit_wb = wb_we && (wb_addr == AW'(g));
    assign hit_ld = ld_we && (ld_addr == AW'(g));
    // instruction write-back takes priority over the load port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (hit_wb) q <= wb_data;
      else if (hit_ld) q <= ld_data;
    end
    assign ent[g] = q;
  end

  assign rk_data  = ent[rk_addr];
  assign re_data  = ent[re_addr];
  assign rt_data  = ent[rt_addr];
  assign dbg_data = ent[dbg_addr];
endmodule

// File: rtl/fsel_pick.sv
module fsel_pick
  import fsel_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0] key,
  input  logic [DW-1:0] els,
  input  logic [DW-1:0] thn,
  output logic          take_thn,
  output logic [DW-1:0] res
);
  always_comb begin
    take_thn = key_passes(key);
    res      = take_thn ? thn : els;
  end
endmodule

// File: rtl/fsel_unit.sv
module fsel_unit
  import fsel_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  insn_valid,
  input  logic [INSN_W-1:0]     insn_word,
  input  logic [FLAG_W-1:0]     stat_flags,
  input  logic                  ld_we,
  input  logic [FLD_W-1:0]      ld_addr,
  input  logic [DATA_W-1:0]     ld_data,
  input  logic [FLD_W-1:0]      dbg_addr,
  output logic [DATA_W-1:0]     dbg_data,
  output logic [FLAG_W-1:0]     cond_fld,
  output logic                  illegal
);
  localparam int NREG = 2 ** FLD_W;

  sel_word_t            fld;
  logic                 acc_ok, acc_bad;
  logic [DATA_W-1:0]    rf_k, rf_e, rf_t;
  logic [DATA_W-1:0]    op_a, op_b, op_c;
  logic [DATA_W-1:0]    sel_res;
  logic                 take_c;

  // pending write-back stage
  logic                 wb_en;
  logic [FLD_W-1:0]     wb_dest;
  logic [DATA_W-1:0]    wb_data;
  logic                 wb_rc;
  logic [FLAG_W-1:0]    wb_flags;

  fsel_decode u_dec (
    .valid (insn_valid),
    .word  (insn_word),
    .fields(fld),
    .hit   (acc_ok),
    .miss  (acc_bad)
  );

  fsel_regfile #(.NREG(NREG), .DW(DATA_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_we   (ld_we),
    .ld_addr (ld_addr),
    .ld_data (ld_data),
    .wb_we   (wb_en),
    .wb_addr (wb_dest),
    .wb_data (wb_data),
    .rk_addr (fld.key),
    .re_addr (fld.els),
    .rt_addr (fld.thn),
    .dbg_addr(dbg_addr),
    .rk_data (rf_k),
    .re_data (rf_e),
    .rt_data (rf_t),
    .dbg_data(dbg_data)
  );

  // forward the not-yet-written result to a following reader
  always_comb begin
    op_a = (wb_en && wb_dest == fld.key) ? wb_data : rf_k;
    op_b = (wb_en && wb_dest == fld.els) ? wb_data : rf_e;
    op_c = (wb_en && wb_dest == fld.thn) ? wb_data : rf_t;
  end

  fsel_pick #(.DW(DATA_W)) u_pick (
    .key     (op_a),
    .els     (op_b),
    .thn     (op_c),
    .take_thn(take_c),
    .res     (sel_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_en    <= 1'b0;
      wb_dest  <= '0;
      wb_data  <= '0;
      wb_rc    <= 1'b0;
      wb_flags <= '0;
      illegal  <= 1'b0;
    end else begin
      wb_en   <= acc_ok;
      illegal <= acc_bad;
      if (acc_ok) begin
        wb_dest  <= fld.dst;
        wb_data  <= sel_res;
        wb_rc    <= fld.rec;
        wb_flags <= stat_flags;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cond_fld <= '0;
    else if (wb_en && wb_rc)   cond_fld <= wb_flags;
  end

  logic unused_take;
  assign unused_take = take_c;
endmodule

// File: rtl/fsel_unit_chk.sv
module fsel_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_ok,
  input logic        acc_bad,
  input logic        illegal,
  input logic        wb_en,
  input logic        wb_rc,
  input logic [3:0]  wb_flags,
  input logic [3:0]  cond_fld,
  input logic [63:0] op_a,
  input logic [63:0] op_b,
  input logic [63:0] op_c,
  input logic [63:0] sel_res
);
  assert_wb_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |=> wb_en);

  assert_illegal_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bad |=> (illegal && !wb_en));

  assert_no_illegal_on_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |=> !illegal);

  assert_cond_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && wb_rc) |=> (cond_fld == $past(wb_flags)));

  assert_cond_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_en && wb_rc) |=> $stable(cond_fld));

  assert_nan_else_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && op_a[62:52] == 11'h7FF && op_a[51:0] != 52'd0) |-> (sel_res == op_b));

  assert_zero_then_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && op_a[62:0] == 63'd0) |-> (sel_res == op_c));
endmodule

bind fsel_unit fsel_unit_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .acc_ok  (acc_ok),
  .acc_bad (acc_bad),
  .illegal (illegal),
  .wb_en   (wb_en),
  .wb_rc   (wb_rc),
  .wb_flags(wb_flags),
  .cond_fld(cond_fld),
  .op_a    (op_a),
  .op_b    (op_b),
  .op_c    (op_c),
  .sel_res (sel_res)
);

// File: tb/fsel_unit_test.sv
module fsel_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic [31:0] insn_word = '0;
  logic [3:0]  stat_flags = '0;
  logic        ld_we = 1'b0;
  logic [4:0]  ld_addr = '0;
  logic [63:0] ld_data = '0;
  logic [4:0]  dbg_addr = '0;
  logic [63:0] dbg_data;
  logic [3:0]  cond_fld;
  logic        illegal;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fsel_unit uut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
    .stat_flags(stat_flags), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data), .cond_fld(cond_fld), .illegal(illegal)
  );

  // {key value, 1 = then-value expected}
  localparam logic [64:0] VEC [12] = '{
    {64'h3FF0_0000_0000_0000, 1'b1},  // +1.0        R3
    {64'hBFF0_0000_0000_0000, 1'b0},  // -1.0        R4
    {64'h0000_0000_0000_0000, 1'b1},  // +0          R3
    {64'h8000_0000_0000_0000, 1'b1},  // -0          R3
    {64'h7FF0_0000_0000_0000, 1'b1},  // +inf        R3
    {64'hFFF0_0000_0000_0000, 1'b0},  // -inf        R4
    {64'h7FF8_0000_0000_0000, 1'b0},  // quiet NaN   R4
    {64'h7FF0_0000_0000_0001, 1'b0},  // signal NaN  R4
    {64'hFFF8_0000_0000_1234, 1'b0},  // -quiet NaN  R4
    {64'h0000_0000_0000_0001, 1'b1},  // +subnormal  R3
    {64'h8000_0000_0000_0001, 1'b0},  // -subnormal  R4
    {64'h7FEF_FFFF_FFFF_FFFF, 1'b1}   // max finite  R3
  };

  function automatic logic [31:0] enc(input logic [4:0] d, k, e, t, input logic rc);
    return {6'd63, d, k, e, t, 5'd23, rc};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [4:0] a, input logic [63:0] v);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = a; ld_data = v;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [63:0] v);
    dbg_addr = a;
    #1 v = dbg_data;
  endtask

  // drive one word; returns at the negedge after the second edge
  task automatic issue(input logic [31:0] w, input logic [3:0] f);
    @(negedge clk);
    insn_valid = 1'b1; insn_word = w; stat_flags = f;
    @(negedge clk);
    insn_valid = 1'b0; stat_flags = 4'hF;
    @(negedge clk);
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [63:0] bval, cval;
    repeat (3) @(negedge clk);
    // R1: reset state
    peek(5'd7, v);
    check("R1 reg", v, 64'd0);
    check("R1 cond", {60'd0, cond_fld}, 64'd0);
    check("R1 illegal", {63'd0, illegal}, 64'd0);
    rst_n = 1'b1;

    // R9: load port
    load(5'd31, 64'hDEAD_BEEF_0123_4567);
    peek(5'd31, v);
    check("R9 load", v, 64'hDEAD_BEEF_0123_4567);

    // vector table: R2 R3 R4 R5
    for (int i = 0; i < 12; i++) begin
      bval = 64'hFFF8_0000_0000_0000 | 64'(i + 17);   // NaN payload as else
      cval = 64'h5A5A_0000_C3C3_0000 ^ 64'(i * 977);
      load(5'd1, VEC[i][64:1]);
      load(5'd2, bval);
      load(5'd3, cval);
      issue(enc(5'(8 + i), 5'd1, 5'd2, 5'd3, 1'b0), 4'h0);
      peek(5'(8 + i), v);
      check(VEC[i][0] ? "R3 then-value" : "R4 else-value", v, VEC[i][0] ? cval : bval);
    end

    // R5: else-value NaN payload copied exactly
    peek(5'd9, v);
    check("R5 bit copy", v, 64'hFFF8_0000_0000_0000 | 64'd18);

    // R6: timing of write-back
    load(5'd1, 64'h3FF0_0000_0000_0000);
    load(5'd3, 64'h1111_2222_3333_4444);
    @(negedge clk);
    insn_valid = 1'b1; insn_word = enc(5'd20, 5'd1, 5'd2, 5'd3, 1'b0);
    @(negedge clk);
    insn_valid = 1'b0;
    peek(5'd20, v);
    check("R6 old after one edge", v, 64'd0);
    @(negedge clk);
    peek(5'd20, v);
    check("R6 new after two edges", v, 64'h1111_2222_3333_4444);

    // R7: record bit loads flags, no record keeps them
    issue(enc(5'd21, 5'd1, 5'd2, 5'd3, 1'b1), 4'b1010);
    check("R7 record load", {60'd0, cond_fld}, {60'd0, 4'b1010});
    issue(enc(5'd21, 5'd1, 5'd2, 5'd3, 1'b0), 4'b0101);
    check("R7 no record hold", {60'd0, cond_fld}, {60'd0, 4'b1010});

    // R8: opcode mismatch
    @(negedge clk);
    insn_valid = 1'b1; insn_word = enc(5'd22, 5'd1, 5'd2, 5'd3, 1'b1) ^ 32'h0000_0002; stat_flags = 4'b0110;
    @(negedge clk);
    insn_valid = 1'b0;
    check("R8 illegal pulse", {63'd0, illegal}, 64'd1);
    @(negedge clk);
    check("R8 illegal drops", {63'd0, illegal}, 64'd0);
    peek(5'd22, v);
    check("R8 no write", v, 64'd0);
    check("R8 cond kept", {60'd0, cond_fld}, {60'd0, 4'b1010});
    issue({6'd62, 26'h0000_02E}, 4'b0001);
    peek(5'd0, v);
    check("R8 wrong primary no write", v, 64'd0);

    // R9: strobe low does nothing
    @(negedge clk);
    insn_word = enc(5'd23, 5'd1, 5'd2, 5'd3, 1'b1); stat_flags = 4'b1111;
    repeat (3) @(negedge clk);
    peek(5'd23, v);
    check("R9 idle no write", v, 64'd0);
    check("R9 idle cond", {60'd0, cond_fld}, {60'd0, 4'b1010});

    // R10: back-to-back forwarding
    load(5'd3, 64'hBFF0_0000_0000_0000);
    load(5'd11, 64'h0000_0000_0000_AAAA);
    load(5'd12, 64'h0000_0000_0000_BBBB);
    load(5'd10, 64'd0);
    @(negedge clk);
    insn_valid = 1'b1; insn_word = enc(5'd10, 5'd1, 5'd2, 5'd3, 1'b0);
    @(negedge clk);
    insn_word = enc(5'd13, 5'd10, 5'd12, 5'd11, 1'b0);
    @(negedge clk);
    insn_valid = 1'b0;
    @(negedge clk);
    peek(5'd13, v);
    check("R10 forwarded key", v, 64'h0000_0000_0000_BBBB);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule